// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host write bus and the write state machine of an embedded flash controller. Each host write carries an address and a data word. The block watches the stream of writes for multi-write command sequences. Every sequence starts with a fixed two-write unlock preamble. When a sequence completes, the block raises a one-cycle, one-hot request for the matching operation. Erase and protect sequences carry a second unlock preamble, and their last write supplies a sector number, which the block latches next to the request.

The block also keeps the read-path selector: array, identifier or status. The selector changes only when an accepted sequence completes. While the write state machine reports that it is busy, the block still tracks sequences. Only a completed read-status or abort sequence turns into a request at that time, and every other completed sequence is dropped.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `req` is all zero, `read_mode` is 2'b00 (array) and `req_sector` is zero.
- R2: A sequence begins only with low byte AAh written at unlock address 5555h, followed by low byte 55h written at unlock address 2AAAh. Only address bits [14:0] are compared, and bits [19:15] do not matter for these writes.
- R3: A third write at 5555h completes a short command. The low byte selects the request bit: F0h sets bit 0 (read array), 90h sets bit 1 (ID read), A0h sets bit 2 (page program), 70h sets bit 5 (read status), 50h sets bit 6 (clear status) and E0h sets bit 7 (abort).
- R4: Setup byte 80h at 5555h, followed by a second AAh/55h preamble, opens an erase. A final 10h at 5555h sets bit 3 (chip erase). A final 30h at any address sets bit 4 (sector erase) and loads address bits [19:15] into `req_sector`.
- R5: Setup byte 60h at 5555h, followed by a second preamble, opens a protect sequence. A final 20h sets bit 8 (protect) and a final 40h sets bit 9 (unprotect), and address bits [19:15] of that write are loaded into `req_sector`.
- R6: A protect or unprotect whose sector is neither 00000b nor 11111b produces no request and leaves `read_mode` and `req_sector` unchanged.
- R7: Data bits [15:8] are ignored in every write.
- R8: If `wsm_busy` is high at the final write, only read status and abort produce a request. Other completed sequences produce no request and change neither `read_mode` nor `req_sector`.
- R9: A write that is not the expected next step abandons the sequence. If that write is itself AAh at 5555h, it counts as a new first unlock write.
- R10: `read_mode` takes 2'b00 after read array, 2'b01 after ID read, and 2'b10 after read status, program, either erase, abort, protect or unprotect. Clear status leaves it unchanged.
- R11: A request is a single-cycle pulse in the cycle after the clock edge that samples the final write. At most one request bit is high.
- R12: Cycles with `wr_en` low do not advance or disturb a sequence in progress, whatever the address and data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one write per cycle when high |
| wr_addr | input | 20 | Write address; [14:0] compared, [19:15] sector |
| wr_data | input | 16 | Write data; only [7:0] decoded |
| wsm_busy | input | 1 | Write state machine has an operation running |
| req | output | 10 | One-hot operation request pulse |
| req_sector | output | 5 | Sector of the latest accepted sector erase, protect or unprotect |
| read_mode | output | 2 | Read-path select: 00 array, 01 ID, 10 status |

## Verification
The bench builds the block with its default parameters: a 20-bit address, a 16-bit data word, a 15-bit compare field and a 5-bit sector field. With these values the unlock addresses have real upper bits to vary, so random values in address bits [19:15] and in the data high byte check that those bits are ignored. All 32 sector numbers are reachable, and protect sequences land on both the valid end sectors and the invalid middle ones. Random command streams with random busy states and stray writes run beside directed cases for restart, gaps between writes and broken preambles.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

    localparam int NUM_CMD = 10;

    typedef enum logic [3:0] {
        CMD_RD_ARRAY = 4'd0,
        CMD_ID       = 4'd1,
        CMD_PROG     = 4'd2,
        CMD_CHIP_ER  = 4'd3,
        CMD_SECT_ER  = 4'd4,
        CMD_RD_STAT  = 4'd5,
        CMD_CLR_STAT = 4'd6,
        CMD_ABORT    = 4'd7,
        CMD_PROT     = 4'd8,
        CMD_UNPROT   = 4'd9
    } cmd_e;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'b00,
        MODE_ID     = 2'b01,
        MODE_STATUS = 2'b10
    } rmode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_LONG_A,
        SQ_LONG_B,
        SQ_LONG_C
    } seq_e;

    localparam logic [7:0] OP_UNL1       = 8'hAA;
    localparam logic [7:0] OP_UNL2       = 8'h55;
    localparam logic [7:0] OP_RD_ARRAY   = 8'hF0;
    localparam logic [7:0] OP_ID         = 8'h90;
    localparam logic [7:0] OP_PROG       = 8'hA0;
    localparam logic [7:0] OP_RD_STAT    = 8'h70;
    localparam logic [7:0] OP_CLR_STAT   = 8'h50;
    localparam logic [7:0] OP_ABORT      = 8'hE0;
    localparam logic [7:0] OP_ER_SETUP   = 8'h80;
    localparam logic [7:0] OP_LOCK_SETUP = 8'h60;
    localparam logic [7:0] OP_CHIP       = 8'h10;
    localparam logic [7:0] OP_SECTOR     = 8'h30;
    localparam logic [7:0] OP_LOCK       = 8'h20;
    localparam logic [7:0] OP_UNLOCK     = 8'h40;

endpackage

// File: rtl/cmd_seq_tracker.sv
`timescale 1ns/1ps
module cmd_seq_tracker
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int CMP_W  = 15,
    parameter int SECT_W = 5,
    parameter logic [CMP_W-1:0] UNLOCK_A = 15'h5555,
    parameter logic [CMP_W-1:0] UNLOCK_B = 15'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hit,
    output cmd_e              hit_cmd,
    output logic [SECT_W-1:0] hit_sector
);

    typedef struct packed {
        seq_e state;
        logic lock_kind;
    } trk_t;

    trk_t trk_d, trk_q;

    logic [CMP_W-1:0] lo_addr;
    logic [7:0]       op_byte;
    logic             at_a, at_b, restart;
    logic             unused_hi;

    assign lo_addr   = wr_addr[CMP_W-1:0];
    assign op_byte   = wr_data[7:0];
    assign unused_hi = ^wr_data[DATA_W-1:8];
    assign at_a      = (lo_addr == UNLOCK_A);
    assign at_b      = (lo_addr == UNLOCK_B);
    assign restart   = at_a && (op_byte == OP_UNL1);

    always_comb begin
        trk_d      = trk_q;
        hit        = 1'b0;
        hit_cmd    = CMD_RD_ARRAY;
        hit_sector = wr_addr[ADDR_W-1 -: SECT_W];
        if (wr_en) begin
            trk_d.state = restart ? SQ_UNL1 : SQ_IDLE;
            case (trk_q.state)
                SQ_IDLE: ;
                SQ_UNL1: begin
                    if (at_b && op_byte == OP_UNL2) trk_d.state = SQ_UNL2;
                end
                SQ_UNL2: begin
                    if (at_a) begin
                        case (op_byte)
                            OP_RD_ARRAY: begin hit = 1'b1; hit_cmd = CMD_RD_ARRAY; end
                            OP_ID:       begin hit = 1'b1; hit_cmd = CMD_ID;       end
                            OP_PROG:     begin hit = 1'b1; hit_cmd = CMD_PROG;     end
                            OP_RD_STAT:  begin hit = 1'b1; hit_cmd = CMD_RD_STAT;  end
                            OP_CLR_STAT: begin hit = 1'b1; hit_cmd = CMD_CLR_STAT; end
                            OP_ABORT:    begin hit = 1'b1; hit_cmd = CMD_ABORT;    end
                            OP_ER_SETUP: begin
                                trk_d.state     = SQ_LONG_A;
                                trk_d.lock_kind = 1'b0;
                            end
                            OP_LOCK_SETUP: begin
                                trk_d.state     = SQ_LONG_A;
                                trk_d.lock_kind = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                SQ_LONG_A: begin
                    if (restart) trk_d.state = SQ_LONG_B;
                end
                SQ_LONG_B: begin
                    if (at_b && op_byte == OP_UNL2) trk_d.state = SQ_LONG_C;
                end
                SQ_LONG_C: begin
                    if (!trk_q.lock_kind) begin
                        if (at_a && op_byte == OP_CHIP) begin
                            hit = 1'b1; hit_cmd = CMD_CHIP_ER;
                        end else if (op_byte == OP_SECTOR) begin
                            hit = 1'b1; hit_cmd = CMD_SECT_ER;
                        end
                    end else begin
                        if (op_byte == OP_LOCK) begin
                            hit = 1'b1; hit_cmd = CMD_PROT;
                        end else if (op_byte == OP_UNLOCK) begin
                            hit = 1'b1; hit_cmd = CMD_UNPROT;
                        end
                    end
                end
                default: trk_d.state = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q.state     <= SQ_IDLE;
            trk_q.lock_kind <= 1'b0;
        end else begin
            trk_q <= trk_d;
        end
    end

    // R12: without a write strobe the sequence position holds
    a_r12_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (trk_q.state == $past(trk_q.state)));

    // R4 / R5: the second preamble is reachable only from the setup step
    a_r4_long_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.state == SQ_LONG_A) |->
            ($past(trk_q.state) == SQ_UNL2 || $past(trk_q.state) == SQ_LONG_A));

endmodule

// File: rtl/cmd_gate.sv
`timescale 1ns/1ps
module cmd_gate
    import flash_cmd_pkg::*;
#(
    parameter int SECT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               busy,
    input  logic               hit,
    input  cmd_e               hit_cmd,
    input  logic [SECT_W-1:0]  hit_sector,
    output logic               accept,
    output logic [NUM_CMD-1:0] req,
    output logic [SECT_W-1:0]  req_sector
);

    typedef struct packed {
        logic [NUM_CMD-1:0] req;
        logic [SECT_W-1:0]  sect;
    } gate_t;

    gate_t gate_d, gate_q;

    logic               sect_ok, is_lock, busy_ok, takes_sect;
    logic [NUM_CMD-1:0] onehot;

    assign sect_ok    = (&hit_sector) || (~|hit_sector);
    assign is_lock    = (hit_cmd == CMD_PROT) || (hit_cmd == CMD_UNPROT);
    assign busy_ok    = !busy || (hit_cmd == CMD_RD_STAT) || (hit_cmd == CMD_ABORT);
    assign takes_sect = is_lock || (hit_cmd == CMD_SECT_ER);
    assign accept     = hit && busy_ok && (!is_lock || sect_ok);

    for (genvar g = 0; g < NUM_CMD; g++) begin : g_req
        assign onehot[g] = accept && (hit_cmd == cmd_e'(g));
    end

    always_comb begin
        gate_d     = gate_q;
        gate_d.req = onehot;
        if (accept && takes_sect) gate_d.sect = hit_sector;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q.req  <= '0;
            gate_q.sect <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign req        = gate_q.req;
    assign req_sector = gate_q.sect;

    // R11: at most one request at a time
    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_q.req));

    // R11: a request lasts exactly one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|gate_q.req) |=> !(|gate_q.req));

    // R8: while busy only status read and abort get through
    a_r8_busy_filter: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gate_q.req) && $past(busy)) |->
            (gate_q.req[CMD_RD_STAT] || gate_q.req[CMD_ABORT]));

    // R6: protect requests carry only an end sector
    a_r6_lock_sector: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q.req[CMD_PROT] || gate_q.req[CMD_UNPROT]) |->
            ((&gate_q.sect) || (~|gate_q.sect)));

endmodule

// File: rtl/read_mode_reg.sv
`timescale 1ns/1ps
module read_mode_reg
    import flash_cmd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   accept,
    input  cmd_e   cmd,
    output rmode_e mode
);

    rmode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (accept) begin
            case (cmd)
                CMD_RD_ARRAY: mode_d = MODE_ARRAY;
                CMD_ID:       mode_d = MODE_ID;
                CMD_CLR_STAT: mode_d = mode_q;
                default:      mode_d = MODE_STATUS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_ARRAY;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;

    // R10: only the three defined encodings appear
    a_r10_legal_mode: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != 2'b11);

endmodule

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int CMP_W  = 15,
    parameter int SECT_W = 5,
    parameter logic [CMP_W-1:0] UNLOCK_A = 15'h5555,
    parameter logic [CMP_W-1:0] UNLOCK_B = 15'h2AAA
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               wsm_busy,
    output logic [NUM_CMD-1:0] req,
    output logic [SECT_W-1:0]  req_sector,
    output logic [1:0]         read_mode
);

    logic              hit, accept;
    cmd_e              hit_cmd;
    logic [SECT_W-1:0] hit_sector;
    rmode_e            mode;

    cmd_seq_tracker #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W), .SECT_W(SECT_W),
        .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hit(hit), .hit_cmd(hit_cmd), .hit_sector(hit_sector)
    );

    cmd_gate #(.SECT_W(SECT_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .busy(wsm_busy), .hit(hit), .hit_cmd(hit_cmd),
        .hit_sector(hit_sector), .accept(accept), .req(req), .req_sector(req_sector)
    );

    read_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n), .accept(accept), .cmd(hit_cmd), .mode(mode)
    );

    assign read_mode = mode;

    // R10: the read path moves only together with an issued request
    a_r10_mode_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        (read_mode != $past(read_mode)) |-> (|req));

endmodule

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        wsm_busy = 1'b0;
    logic [9:0]  req;
    logic [4:0]  req_sector;
    logic [1:0]  read_mode;

    logic [9:0]  s_req;
    logic [4:0]  s_sect;
    logic [1:0]  s_mode;
    logic [1:0]  exp_mode = 2'b00;
    logic [4:0]  exp_sect = 5'd0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wsm_busy(wsm_busy), .req(req),
        .req_sector(req_sector), .read_mode(read_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        s_req = req; s_mode = read_mode; s_sect = req_sector;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] code3(input int c);
        case (c)
            0: return 8'hF0; 1: return 8'h90; 2: return 8'hA0;
            5: return 8'h70; 6: return 8'h50; default: return 8'hE0;
        endcase
    endfunction

    function automatic logic [1:0] mode_of(input int c, input logic [1:0] cur);
        if (c == 0) return 2'b00;
        if (c == 1) return 2'b01;
        if (c == 6) return cur;
        return 2'b10;
    endfunction

    function automatic logic [19:0] at(input logic [14:0] lo);
        logic [4:0] hi = 5'($urandom);
        return {hi, lo};
    endfunction

    function automatic logic [15:0] dv(input logic [7:0] lo);
        logic [7:0] hi = 8'($urandom);
        return {hi, lo};
    endfunction

    // issue command c (0..9) with sector s and check the outcome
    task automatic run_cmd(input int c, input logic [4:0] s, input string tag);
        logic acc;
        logic [9:0] er;
        wr(at(15'h5555), dv(8'hAA));
        wr(at(15'h2AAA), dv(8'h55));
        if (c == 3 || c == 4) begin
            wr(at(15'h5555), dv(8'h80));
            wr(at(15'h5555), dv(8'hAA));
            wr(at(15'h2AAA), dv(8'h55));
            if (c == 3) wr(at(15'h5555), dv(8'h10));
            else        wr({s, 15'($urandom)}, dv(8'h30));
        end else if (c == 8 || c == 9) begin
            wr(at(15'h5555), dv(8'h60));
            wr(at(15'h5555), dv(8'hAA));
            wr(at(15'h2AAA), dv(8'h55));
            wr({s, 15'($urandom)}, dv(c == 8 ? 8'h20 : 8'h40));
        end else begin
            wr(at(15'h5555), dv(code3(c)));
        end
        acc = !wsm_busy || c == 5 || c == 7;
        if ((c == 8 || c == 9) && !(s == 5'h00 || s == 5'h1F)) acc = 1'b0;
        er = acc ? (10'b1 << c) : 10'b0;
        if (acc) exp_mode = mode_of(c, exp_mode);
        if (acc && (c == 4 || c == 8 || c == 9)) exp_sect = s;
        check({tag, " req"}, 32'(s_req), 32'(er));
        check({tag, " read_mode R10"}, 32'(s_mode), 32'(exp_mode));
        check({tag, " req_sector"}, 32'(s_sect), 32'(exp_sect));
        @(posedge clk); #1;
        check({tag, " pulse R11"}, 32'(req), 32'd0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset req", 32'(req), 32'd0);
        check("R1 reset mode", 32'(read_mode), 32'd0);
        check("R1 reset sector", 32'(req_sector), 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R3 / R4 / R5: every command once, not busy
        run_cmd(1, 5'd0, "R3 id");
        run_cmd(0, 5'd0, "R3 read array");
        run_cmd(2, 5'd0, "R3 program");
        run_cmd(6, 5'd0, "R3 clear status");
        run_cmd(0, 5'd0, "R3 read array");
        run_cmd(5, 5'd0, "R3 read status");
        run_cmd(7, 5'd0, "R3 abort");
        run_cmd(3, 5'd0, "R4 chip erase");
        run_cmd(4, 5'd13, "R4 sector erase");
        run_cmd(8, 5'h1F, "R5 protect");
        run_cmd(9, 5'h00, "R5 unprotect");
        run_cmd(0, 5'd0, "R3 read array");
        // R6: invalid protect sector
        run_cmd(8, 5'd6, "R6 protect bad sector");
        run_cmd(9, 5'd17, "R6 unprotect bad sector");
        // R8: busy filtering
        wsm_busy = 1'b1;
        run_cmd(2, 5'd0, "R8 program busy");
        run_cmd(4, 5'd3, "R8 sector erase busy");
        run_cmd(1, 5'd0, "R8 id busy");
        run_cmd(5, 5'd0, "R8 read status busy");
        run_cmd(7, 5'd0, "R8 abort busy");
        wsm_busy = 1'b0;
        run_cmd(0, 5'd0, "R3 read array");

        // R9: a wrong third write abandons the sequence
        wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055);
        wr(20'h05555, 16'h0012); wr(20'h05555, 16'h0070);
        check("R9 abandoned req", 32'(s_req), 32'd0);
        check("R9 abandoned mode", 32'(s_mode), 32'(exp_mode));
        // R9: repeated first write restarts
        wr(20'h05555, 16'h00AA); wr(20'h05555, 16'h00AA);
        wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h0090);
        check("R9 restart req", 32'(s_req), 32'h2);
        exp_mode = 2'b01;
        check("R9 restart mode", 32'(s_mode), 32'(exp_mode));
        // R9: wrong write during second preamble restarts with AAh
        wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h0080);
        wr(20'h05555, 16'h00AA); wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055);
        wr(20'h05555, 16'h00F0);
        check("R9 restart from long req", 32'(s_req), 32'h1);
        exp_mode = 2'b00;

        // R2: wrong compared address bit breaks the preamble
        wr(20'h05554, 16'h00AA); wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h0070);
        check("R2 bad unlock addr", 32'(s_req), 32'd0);
        // R2: upper address bits ignored in the preamble
        wr(20'hF5555, 16'h00AA); wr(20'hAAAAA, 16'h0055); wr(20'h3D555, 16'h0070);
        check("R2 upper addr ignored", 32'(s_req), 32'h20);
        exp_mode = 2'b10;
        // R7: high data byte ignored
        wr(20'h05555, 16'h55AA); wr(20'h02AAA, 16'hAA55); wr(20'h05555, 16'h90F0);
        check("R7 high byte ignored", 32'(s_req), 32'h1);
        exp_mode = 2'b00;

        // R12: idle cycles with a matching pattern on the bus do not advance
        wr(20'h05555, 16'h00AA);
        @(negedge clk); wr_addr = 20'h02AAA; wr_data = 16'h0055;
        repeat (3) @(negedge clk);
        wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h0070);
        check("R12 gaps ignored", 32'(s_req), 32'h20);
        exp_mode = 2'b10;

        // random streams
        for (int i = 0; i < 300; i++) begin
            int c = int'($urandom_range(0, 9));
            logic [4:0] s = 5'($urandom);
            if ((c == 8 || c == 9) && $urandom_range(0, 1) == 0)
                s = ($urandom_range(0, 1) == 0) ? 5'h00 : 5'h1F;
            if ($urandom_range(0, 4) == 0) begin
                logic [7:0] g = 8'($urandom);
                if (g == 8'hAA) g = 8'h00;
                wr(20'($urandom), {8'($urandom), g});
            end
            wsm_busy = ($urandom_range(0, 3) == 0);
            run_cmd(c, s, wsm_busy ? "R8 random busy" : "R3 random");
            wsm_busy = 1'b0;
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule